// File: doc/BRIEF.md
# Retimed Mux-D Scan Chain

This block is a scan chain of configurable length. Each cell behaves exactly like a conventional mux-D scan flip-flop, but the storage has been moved in front of the scan multiplexer. Each cell has two registers. One register loads the functional data input on every clock. A shadow register loads the scan-path input on every clock. A multiplexer after the two registers chooses between them. One register shared by the whole chain samples scan enable, and its output, scan enable delayed by one cycle, drives the select of every cell's multiplexer. This arrangement keeps the scan multiplexer off the setup side of the functional path.

An optional origin split gives each cell a second copy of both registers. One copy drives the functional output and the other drives the scan path into the next cell, so the scan fanout no longer loads the functional net. Both variants behave identically at the ports, cycle for cycle, to a standard mux-D chain in capture and in shift. Test patterns written for that chain therefore apply without change.

Top module: `rscan_chain`

## Requirements
- R1: When scan_en_i was low at a rising clock edge, q_o after that edge equals data_i as sampled at that edge, bit for bit (data_i[i] goes to q_o[i]).
- R2: When scan_en_i was high at a rising clock edge, q_o[0] after the edge equals scan_in_i sampled at that edge. For every i from 1 to N-1, q_o[i] after the edge equals q_o[i-1] from before the edge.
- R3: scan_out_o always equals q_o[N-1].
- R4: While rst_ni is low, every q_o bit and scan_out_o read zero. The reset takes effect without waiting for a clock edge.
- R5: The origin-split variant (SPLIT_ORIGIN=1) and the single-copy variant (SPLIT_ORIGIN=0) produce identical q_o and scan_out_o for the same stimulus.
- R6: Suppose a word w is shifted in over N consecutive shift cycles, with bit w[N-1] entered first. After the last of those shift edges, q_o equals w.
- R7: Any pattern of scan_en_i, including a change of value on every cycle, gives the same output on every cycle as a conventional mux-D chain that is reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Scan enable: 1 selects shift, 0 selects capture |
| scan_in_i | input | 1 | Serial input to cell 0 |
| data_i | input | N | Functional data, one bit per cell |
| q_o | output | N | Cell outputs |
| scan_out_o | output | 1 | Serial output of the last cell |

## Verification
The case that needs most care is a capture and a shift falling on adjacent edges. When scan enable flips between two clocks, the multiplexer select changes in the same cycle that both registers of every cell load new values. A wrong alignment of the delayed enable would then show the wrong register. The bench provokes this with a directed run in which scan enable toggles on every cycle, and with random phases that use several toggle densities. It judges every cycle by comparing all outputs of both variants with a behavioural conventional chain computed in the bench.

// File: rtl/rscan_pkg.sv
package rscan_pkg;
  typedef enum logic {
    SEL_FUNC = 1'b0,
    SEL_SCAN = 1'b1
  } sel_e;
endpackage

// File: rtl/rscan_en_reg.sv
module rscan_en_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_d_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_d_o <= 1'b0;
    else         en_d_o <= en_i;
  end
endmodule

// File: rtl/rscan_cell.sv
module rscan_cell #(
  parameter bit SPLIT_ORIGIN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic d_i,
  input  logic si_i,
  output logic func_o,
  output logic scan_o
);
  import rscan_pkg::*;

  sel_e sel;
  assign sel = sel_e'(sel_i);

  if (SPLIT_ORIGIN) begin : g_split
    // separate copies keep scan fanout off the functional net
    logic fn_f, fn_s, sc_f, sc_s;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fn_f <= 1'b0; fn_s <= 1'b0;
        sc_f <= 1'b0; sc_s <= 1'b0;
      end else begin
        fn_f <= d_i;  fn_s <= si_i;
        sc_f <= d_i;  sc_s <= si_i;
      end
    end
    assign func_o = (sel == SEL_SCAN) ? fn_s : fn_f;
    assign scan_o = (sel == SEL_SCAN) ? sc_s : sc_f;
  end else begin : g_single
    logic f_q, s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q <= 1'b0; s_q <= 1'b0;
      end else begin
        f_q <= d_i;  s_q <= si_i;
      end
    end
    assign func_o = (sel == SEL_SCAN) ? s_q : f_q;
    assign scan_o = func_o;
  end
endmodule

// File: rtl/rscan_chain.sv
module rscan_chain #(
  parameter int N            = 8,
  parameter bit SPLIT_ORIGIN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         scan_en_i,
  input  logic         scan_in_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] q_o,
  output logic         scan_out_o
);
  localparam int LAST = N - 1;

  logic         en_d;
  logic [N-1:0] scan_path;
  logic [N-1:0] scan_src;

  rscan_en_reg u_en_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (scan_en_i),
    .en_d_o (en_d)
  );

  assign scan_src[0] = scan_in_i;

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i > 0) begin : g_link
      assign scan_src[i] = scan_path[i-1];
    end
    rscan_cell #(.SPLIT_ORIGIN(SPLIT_ORIGIN)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (en_d),
      .d_i    (data_i[i]),
      .si_i   (scan_src[i]),
      .func_o (q_o[i]),
      .scan_o (scan_path[i])
    );
  end

  assign scan_out_o = scan_path[LAST];
endmodule

// File: rtl/rscan_chain_chk.sv
module rscan_chain_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scan_en_i,
  input logic         scan_in_i,
  input logic [N-1:0] data_i,
  input logic [N-1:0] q_o,
  input logic         scan_out_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(scan_en_i)) |-> (q_o == $past(data_i)));

  // R2
  shift_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(scan_en_i)) |-> (q_o[0] == $past(scan_in_i)));

  // R2
  shift_body_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(scan_en_i)) |-> (q_o[N-1:1] == $past(q_o[N-2:0])));

  // R3
  scan_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_out_o == q_o[N-1]);

  // R4
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && !scan_out_o));
endmodule

bind rscan_chain rscan_chain_chk #(.N(N)) u_rscan_chain_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scan_en_i  (scan_en_i),
  .scan_in_i  (scan_in_i),
  .data_i     (data_i),
  .q_o        (q_o),
  .scan_out_o (scan_out_o)
);

// File: tb/rscan_chain_bench.sv
module rscan_chain_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         se = 1'b0;
  logic         si = 1'b0;
  logic [N-1:0] d = '0;
  logic [N-1:0] q_a, q_b;
  logic         so_a, so_b;

  logic [N-1:0] ref_q;
  logic         last_se;
  int           checks = 0;
  int           fails  = 0;

  always #4 clk = ~clk;

  rscan_chain #(.N(N), .SPLIT_ORIGIN(1'b1)) u_rscan_chain (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(se), .scan_in_i(si),
    .data_i(d), .q_o(q_a), .scan_out_o(so_a)
  );

  rscan_chain #(.N(N), .SPLIT_ORIGIN(1'b0)) u_rscan_chain_plain (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(se), .scan_in_i(si),
    .data_i(d), .q_o(q_b), .scan_out_o(so_b)
  );

  function automatic logic [N-1:0] next_ref(input logic [N-1:0] q, input logic s,
                                            input logic in, input logic [N-1:0] dd);
    return s ? {q[N-2:0], in} : dd;
  endfunction

  // conventional mux-D reference chain
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      last_se <= 1'b0;
    end else begin
      ref_q   <= next_ref(ref_q, se, si, d);
      last_se <= se;
    end
  end

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string tag;
    if (!rst_n)       tag = "R4";
    else if (last_se) tag = "R2/R7";
    else              tag = "R1/R7";
    check(tag, q_a, ref_q);
    check("R5", q_b, q_a);
    check("R3", {{(N-1){1'b0}}, so_a}, {{(N-1){1'b0}}, ref_q[N-1]});
    check("R5", {{(N-1){1'b0}}, so_b}, {{(N-1){1'b0}}, so_a});
  endtask

  task automatic step(input logic s, input logic in, input logic [N-1:0] dd);
    @(negedge clk);
    compare_all();
    se = s; si = in; d = dd;
  endtask

  initial begin
    logic [N-1:0] w;
    #1 rst_n = 1'b0;
    #1;
    // R4: cleared without a clock edge
    check("R4", q_a, '0);
    check("R4", {{(N-1){1'b0}}, so_a}, '0);
    step(1'b1, 1'b1, '1);
    step(1'b1, 1'b1, '1);
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;

    // R1: capture all ones, then a checkerboard
    step(1'b0, 1'b0, '1);
    step(1'b0, 1'b1, {(N/2){2'b10}});
    step(1'b0, 1'b0, '0);

    // R6: shift a known word in, first bit entered is w[N-1]
    w = 8'hA7;
    for (int k = 0; k < N; k++) step(1'b1, w[N-1-k], $urandom);
    @(negedge clk);
    check("R6", q_a, w);
    check("R6", q_b, w);
    compare_all();
    se = 1'b1; si = 1'b0;

    // R7: scan enable toggles every cycle
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 60; k++) step(k[0], 1'($urandom), N'($urandom));

    // random phases with different toggle densities
    for (int ph = 0; ph < 6; ph++) begin
      for (int k = 0; k < 400; k++) begin
        logic s;
        case (ph % 3)
          0: s = ($urandom % 8) == 0;
          1: s = ($urandom % 8) != 0;
          default: s = 1'($urandom);
        endcase
        step(s, 1'($urandom), N'($urandom));
      end
    end

    // R4: asynchronous reset in the middle of a run
    step(1'b0, 1'b0, '1);
    step(1'b1, 1'b1, '1);
    @(negedge clk);
    compare_all();
    rst_n = 1'b0;
    #1;
    check("R4", q_a, '0);
    check("R4", q_b, '0);
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) step(1'($urandom), 1'($urandom), N'($urandom));
    @(negedge clk);
    compare_all();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule